// File: doc/BRIEF.md
# Transactional Cache Read-Set Tracker

This block keeps the per-node cache-side state needed for a commit-broadcast style of transactional memory. While a transaction is open it marks every tracked cache line that a load hits, keeps the line address of any marked line that a fill pushes out in a small address-only victim list, and holds the transaction's stores in a local buffer so that no other node sees them early.

When the core ends the transaction, the tracker asks the interconnect for the broadcast channel. Once the grant arrives it sends every buffered store, one per cycle and in issue order, as a single uninterrupted burst. It then reports the commit. At the same time it watches the addresses that other nodes commit. If one of those addresses falls on a marked line or a victim entry, it requests a rollback. It also requests an abort when the store buffer or the victim list has no room left. Every outcome clears the transaction's state. At the start of each transaction it raises a checkpoint request for the core's register state.

Top module: `txrs_tracker`

## Requirements
- R1: After reset, `in_txn`, `bc_req`, `bc_valid`, `bc_last`, `ckpt_req`, `rollback`, `ovf_abort` and `commit_done` are all low.
- R2: `tx_begin` while idle makes `ckpt_req` high for exactly the next cycle and sets `in_txn` from that cycle on.
- R3: A load during an open transaction whose address equals the tag of a valid tracked line marks that line. A later snoop to a marked line's address makes `rollback` high for one cycle, one cycle after the snoop, and ends the transaction. A snoop to an unmarked line or an untracked address has no effect.
- R4: A fill that replaces a marked line keeps that line's address in the victim list, and a later snoop to that address causes a rollback as in R3. Replacing an unmarked line keeps nothing.
- R5: On commit, the buffered stores appear on `bc_addr`/`bc_data` with `bc_valid` high, one per cycle in issue order. The first appears in the cycle after the cycle in which `bc_gnt` is sampled high, and `bc_last` is high only on the final one.
- R6: After `tx_end` with buffered stores, `bc_req` stays high from the next cycle until the final beat, and `commit_done` pulses in the cycle after the final beat. With an empty buffer, `commit_done` pulses in the cycle after `tx_end` and `bc_req` stays low.
- R7: After a commit or a rollback, no marks, victim entries or buffered stores remain. A snoop to a previously marked address no longer causes a rollback, and the next commit sends only the stores of its own transaction.
- R8: A store that finds the buffer full, or an eviction of a marked line that finds the victim list full, makes `ovf_abort` high for one cycle, one cycle later, and ends the transaction.
- R9: A snoop that arrives while the commit burst is running is ignored: the burst completes and `rollback` stays low.
- R10: When a conflicting snoop and `tx_end` arrive in the same cycle, the rollback wins: `rollback` pulses, and neither `bc_req` nor `commit_done` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_begin | input | 1 | Open a transaction (pulse) |
| tx_end | input | 1 | Request commit of the open transaction (pulse) |
| ld_valid | input | 1 | Load access this cycle |
| ld_addr | input | ADDR_W | Line address of the load |
| fill_valid | input | 1 | Install a line into a way |
| fill_way | input | WAY_W | Way being replaced |
| fill_addr | input | ADDR_W | Line address being installed |
| st_valid | input | 1 | Transactional store this cycle |
| st_addr | input | ADDR_W | Store line address |
| st_data | input | DATA_W | Store data |
| snp_valid | input | 1 | Another node's committed address is present |
| snp_addr | input | ADDR_W | Snooped committed address |
| bc_gnt | input | 1 | Broadcast channel grant, held through the burst |
| ckpt_req | output | 1 | Register checkpoint request (pulse) |
| in_txn | output | 1 | A transaction is open or committing |
| bc_req | output | 1 | Broadcast channel request |
| bc_valid | output | 1 | A store beat is on the broadcast bus |
| bc_addr | output | ADDR_W | Beat address |
| bc_data | output | DATA_W | Beat data |
| bc_last | output | 1 | Final beat of the burst |
| rollback | output | 1 | Conflict rollback request (pulse) |
| ovf_abort | output | 1 | Capacity abort (pulse) |
| commit_done | output | 1 | Commit finished (pulse) |

## Verification
Snoop detection is swept over every subset of marked ways crossed with a snoop to each way. This separates real read-set hits from tag-only matches, and it shows that one way's mark does not reach another way. Commits are swept over every buffer fill level from empty to full against grant delays of zero to two cycles. This checks the beat order, the placement of the last beat and the holding of the request, and it separates the empty-commit shortcut from the burst path. Directed sequences cover eviction into the victim list, capacity aborts on each structure, a snoop during the burst, a snoop in the same cycle as `tx_end`, and the clearing of state between transactions.

// File: rtl/txrs_pkg.sv
package txrs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_OPEN     = 2'd1,
        ST_WAIT_GNT = 2'd2,
        ST_BURST    = 2'd3
    } txn_state_e;

    // How a transaction finishes; at most one field is set in a cycle
    typedef struct packed {
        logic conflict;
        logic capacity;
        logic committed;
    } txn_outcome_t;

    function automatic logic outcome_any(txn_outcome_t o);
        return o.conflict | o.capacity | o.committed;
    endfunction

endpackage

// File: rtl/txrs_line_tags.sv
module txrs_line_tags #(
    parameter int ADDR_W = 8,
    parameter int NLINES = 4,
    localparam int WAY_W = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mark_en,
    input  logic [ADDR_W-1:0] mark_addr,
    input  logic              fill_en,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              clr_marks,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_hit,
    output logic              evict_valid,
    output logic [ADDR_W-1:0] evict_addr
);

    logic [NLINES-1:0] vld_v;
    logic [NLINES-1:0] mark_v;
    logic [NLINES-1:0] hit_v;
    logic [ADDR_W-1:0] tag_v [NLINES];

    for (genvar w = 0; w < NLINES; w++) begin : g_way
        logic              vld_q;
        logic              mark_q;
        logic [ADDR_W-1:0] tag_q;
        logic              filled;

        assign filled = fill_en && (fill_way == WAY_W'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q  <= 1'b0;
                mark_q <= 1'b0;
                tag_q  <= '0;
            end else if (filled) begin
                vld_q  <= 1'b1;
                mark_q <= 1'b0;
                tag_q  <= fill_addr;
            end else if (clr_marks) begin
                mark_q <= 1'b0;
            end else if (mark_en && vld_q && (tag_q == mark_addr)) begin
                mark_q <= 1'b1;
            end
        end

        assign vld_v[w]  = vld_q;
        assign mark_v[w] = mark_q;
        assign tag_v[w]  = tag_q;
        assign hit_v[w]  = vld_q && mark_q && (tag_q == snp_addr);
    end

    assign snp_hit     = |hit_v;
    assign evict_valid = fill_en && vld_v[fill_way] && mark_v[fill_way];
    assign evict_addr  = tag_v[fill_way];

endmodule

// File: rtl/txrs_victim_list.sv
module txrs_victim_list #(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 2,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              full,
    output logic              snp_hit
);

    logic [CW-1:0]     cnt_q;
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DEPTH-1:0]  hit_v;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (push && !full) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) begin
            addr_q[cnt_q[IW-1:0]] <= push_addr;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        assign hit_v[i] = (CW'(i) < cnt_q) && (addr_q[i] == snp_addr);
    end

    assign full    = (cnt_q == CW'(DEPTH));
    assign snp_hit = |hit_v;

endmodule

// File: rtl/txrs_store_buf.sv
module txrs_store_buf #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic              full,
    output logic              empty,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data,
    output logic              head_last
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } sb_entry_t;

    sb_entry_t     mem_q [DEPTH];
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
            rd_q  <= '0;
        end else begin
            if (push && !full) cnt_q <= cnt_q + CW'(1);
            if (pop)           rd_q  <= rd_q + IW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) begin
            mem_q[cnt_q[IW-1:0]] <= '{addr: push_addr, data: push_data};
        end
    end

    assign full      = (cnt_q == CW'(DEPTH));
    assign empty     = (cnt_q == '0);
    assign head_addr = mem_q[rd_q].addr;
    assign head_data = mem_q[rd_q].data;
    assign head_last = ((CW'(rd_q) + CW'(1)) == cnt_q);

endmodule

// File: rtl/txrs_tracker.sv
module txrs_tracker
    import txrs_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int NLINES     = 4,
    parameter int VICT_DEPTH = 2,
    parameter int SB_DEPTH   = 4,
    localparam int WAY_W = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_begin,
    input  logic              tx_end,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              fill_valid,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              bc_gnt,
    output logic              ckpt_req,
    output logic              in_txn,
    output logic              bc_req,
    output logic              bc_valid,
    output logic [ADDR_W-1:0] bc_addr,
    output logic [DATA_W-1:0] bc_data,
    output logic              bc_last,
    output logic              rollback,
    output logic              ovf_abort,
    output logic              commit_done
);

    txn_state_e   state_q, state_d;
    txn_outcome_t outc_d, outc_q;
    logic         ckpt_q;

    logic st_open, st_wait, st_burst, st_idle;
    logic tag_hit, vict_hit, vict_full;
    logic evict_valid;
    logic [ADDR_W-1:0] evict_addr;
    logic sb_full, sb_empty, sb_last;
    logic conflict, capacity, clr_all;

    assign st_idle  = (state_q == ST_IDLE);
    assign st_open  = (state_q == ST_OPEN);
    assign st_wait  = (state_q == ST_WAIT_GNT);
    assign st_burst = (state_q == ST_BURST);

    txrs_line_tags #(.ADDR_W(ADDR_W), .NLINES(NLINES)) u_tags (
        .clk         (clk),
        .rst         (rst),
        .mark_en     (st_open && ld_valid),
        .mark_addr   (ld_addr),
        .fill_en     (fill_valid),
        .fill_way    (fill_way),
        .fill_addr   (fill_addr),
        .clr_marks   (clr_all),
        .snp_addr    (snp_addr),
        .snp_hit     (tag_hit),
        .evict_valid (evict_valid),
        .evict_addr  (evict_addr)
    );

    txrs_victim_list #(.ADDR_W(ADDR_W), .DEPTH(VICT_DEPTH)) u_vict (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr_all),
        .push      (st_open && evict_valid),
        .push_addr (evict_addr),
        .snp_addr  (snp_addr),
        .full      (vict_full),
        .snp_hit   (vict_hit)
    );

    txrs_store_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(SB_DEPTH)) u_sbuf (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr_all),
        .push      (st_open && st_valid),
        .push_addr (st_addr),
        .push_data (st_data),
        .pop       (st_burst),
        .full      (sb_full),
        .empty     (sb_empty),
        .head_addr (bc_addr),
        .head_data (bc_data),
        .head_last (sb_last)
    );

    // Conflicts count until the grant is sampled; the burst itself is immune
    assign conflict = snp_valid && (st_open || st_wait) && (tag_hit || vict_hit);
    assign capacity = st_open && ((st_valid && sb_full) || (evict_valid && vict_full));

    always_comb begin
        state_d = state_q;
        outc_d  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_begin) state_d = ST_OPEN;
            end
            ST_OPEN: begin
                if (conflict) begin
                    state_d = ST_IDLE;
                    outc_d.conflict = 1'b1;
                end else if (capacity) begin
                    state_d = ST_IDLE;
                    outc_d.capacity = 1'b1;
                end else if (tx_end) begin
                    if (sb_empty) begin
                        state_d = ST_IDLE;
                        outc_d.committed = 1'b1;
                    end else begin
                        state_d = ST_WAIT_GNT;
                    end
                end
            end
            ST_WAIT_GNT: begin
                if (conflict) begin
                    state_d = ST_IDLE;
                    outc_d.conflict = 1'b1;
                end else if (bc_gnt) begin
                    state_d = ST_BURST;
                end
            end
            ST_BURST: begin
                if (sb_last) begin
                    state_d = ST_IDLE;
                    outc_d.committed = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign clr_all = outcome_any(outc_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            outc_q  <= '0;
            ckpt_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            outc_q  <= outc_d;
            ckpt_q  <= st_idle && tx_begin;
        end
    end

    assign ckpt_req    = ckpt_q;
    assign in_txn      = !st_idle;
    assign bc_req      = st_wait || st_burst;
    assign bc_valid    = st_burst;
    assign bc_last     = st_burst && sb_last;
    assign rollback    = outc_q.conflict;
    assign ovf_abort   = outc_q.capacity;
    assign commit_done = outc_q.committed;

endmodule

// File: rtl/txrs_tracker_chk.sv
module txrs_tracker_chk (
    input logic clk,
    input logic rst,
    input logic tx_begin,
    input logic bc_gnt,
    input logic ckpt_req,
    input logic bc_req,
    input logic bc_valid,
    input logic bc_last,
    input logic rollback,
    input logic ovf_abort,
    input logic commit_done
);

    // R2: a checkpoint request only follows a begin pulse
    assert_ckpt_follows_begin_R2: assert property (@(posedge clk) disable iff (rst)
        ckpt_req |-> $past(tx_begin));

    // R5: beats only while requested and granted
    assert_beat_under_grant_R5: assert property (@(posedge clk) disable iff (rst)
        bc_valid |-> (bc_req && bc_gnt));

    // R5: burst is contiguous until its last beat
    assert_burst_contiguous_R5: assert property (@(posedge clk) disable iff (rst)
        (bc_valid && !bc_last) |=> bc_valid);

    // R6: final beat is followed by the commit pulse
    assert_done_after_last_R6: assert property (@(posedge clk) disable iff (rst)
        (bc_valid && bc_last) |=> commit_done);

    // R8: outcomes are mutually exclusive
    assert_single_outcome_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rollback, ovf_abort, commit_done}));

    // R9: a beat is never followed by a rollback
    assert_no_rollback_after_beat_R9: assert property (@(posedge clk) disable iff (rst)
        bc_valid |=> !rollback);

endmodule

bind txrs_tracker txrs_tracker_chk u_chk (.*);

// File: tb/txrs_tracker_tb.sv
module txrs_tracker_tb;

    localparam int AW = 8;
    localparam int DW = 8;
    localparam int NL = 4;
    localparam int VD = 2;
    localparam int SD = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tx_begin = 0, tx_end = 0, ld_valid = 0, fill_valid = 0;
    logic          st_valid = 0, snp_valid = 0, bc_gnt = 0;
    logic [AW-1:0] ld_addr = '0, fill_addr = '0, st_addr = '0, snp_addr = '0;
    logic [1:0]    fill_way = '0;
    logic [DW-1:0] st_data = '0;
    logic          ckpt_req, in_txn, bc_req, bc_valid, bc_last;
    logic          rollback, ovf_abort, commit_done;
    logic [AW-1:0] bc_addr;
    logic [DW-1:0] bc_data;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic [AW-1:0] ea [4];
    logic [DW-1:0] ed [4];

    always #10 clk = ~clk;

    txrs_tracker #(.ADDR_W(AW), .DATA_W(DW), .NLINES(NL),
                   .VICT_DEPTH(VD), .SB_DEPTH(SD)) u_dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_begin();
        tx_begin = 1; step(); tx_begin = 0;
        chk("R2 ckpt_req pulse", ckpt_req, 1);
        chk("R2 in_txn set", in_txn, 1);
    endtask

    task automatic do_load(input logic [AW-1:0] a);
        ld_valid = 1; ld_addr = a; step(); ld_valid = 0;
    endtask

    task automatic do_fill(input int w, input logic [AW-1:0] a);
        fill_valid = 1; fill_way = 2'(w); fill_addr = a; step(); fill_valid = 0;
    endtask

    task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
        st_valid = 1; st_addr = a; st_data = d; step(); st_valid = 0;
    endtask

    task automatic do_snoop(input logic [AW-1:0] a);
        snp_valid = 1; snp_addr = a; step(); snp_valid = 0;
    endtask

    task automatic do_commit(input int n, input int g);
        tx_end = 1; step(); tx_end = 0;
        if (n == 0) begin
            chk("R6 empty commit done", commit_done, 1);
            chk("R6 empty commit no req", bc_req, 0);
        end else begin
            chk("R6 req after tx_end", bc_req, 1);
            chk("R5 no beat before grant", bc_valid, 0);
            for (int k = 0; k < g; k++) begin
                step();
                chk("R6 req held waiting", bc_req, 1);
                chk("R5 no beat while waiting", bc_valid, 0);
            end
            bc_gnt = 1; step();
            for (int i = 0; i < n; i++) begin
                chk("R5 beat valid", bc_valid, 1);
                chk("R6 req held in burst", bc_req, 1);
                chk("R5 beat addr", bc_addr, ea[i]);
                chk("R5 beat data", bc_data, ed[i]);
                chk("R5 last flag", bc_last, (i == n - 1) ? 1 : 0);
                step();
            end
            chk("R6 commit_done after last", commit_done, 1);
            chk("R6 req dropped", bc_req, 0);
            bc_gnt = 0;
        end
        chk("R7 txn closed", in_txn, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                failures++;
                $display("FAIL watchdog actual=hung expected=finished");
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) step();
        rst = 0;
        step();
        // R1
        chk("R1 in_txn", in_txn, 0);
        chk("R1 bc_req", bc_req, 0);
        chk("R1 bc_valid", bc_valid, 0);
        chk("R1 bc_last", bc_last, 0);
        chk("R1 ckpt_req", ckpt_req, 0);
        chk("R1 rollback", rollback, 0);
        chk("R1 ovf_abort", ovf_abort, 0);
        chk("R1 commit_done", commit_done, 0);

        for (int w = 0; w < NL; w++) do_fill(w, 8'(8'h10 + w));

        // R3: every marked subset crossed with a snoop to each way
        for (int m = 0; m < 16; m++) begin
            for (int w = 0; w < NL; w++) begin
                do_begin();
                step();
                chk("R2 ckpt single cycle", ckpt_req, 0);
                for (int v = 0; v < NL; v++)
                    if (m[v]) do_load(8'(8'h10 + v));
                do_load(8'h80);
                do_snoop(8'h80);
                chk("R3 untracked snoop ignored", rollback, 0);
                do_snoop(8'(8'h10 + w));
                chk("R3 snoop vs mark", rollback, m[w] ? 1 : 0);
                chk("R3 txn state after snoop", in_txn, m[w] ? 0 : 1);
                if (!m[w]) do_commit(0, 0);
            end
        end

        // R5/R6: buffer level x grant delay
        for (int n = 0; n <= SD; n++) begin
            for (int g = 0; g < 3; g++) begin
                do_begin();
                for (int i = 0; i < n; i++) begin
                    ea[i] = 8'(8'h40 + n * 8 + i);
                    ed[i] = 8'(i * 37 + n * 5 + g);
                    do_store(ea[i], ed[i]);
                end
                do_commit(n, g);
            end
        end

        // R4: marked eviction goes to victim list
        do_begin();
        do_load(8'h11);
        do_fill(1, 8'h21);
        do_snoop(8'h11);
        chk("R4 victim snoop rollback", rollback, 1);
        do_fill(1, 8'h11);
        // R4: unmarked eviction keeps nothing
        do_begin();
        do_fill(2, 8'h22);
        do_snoop(8'h12);
        chk("R4 unmarked evict no rollback", rollback, 0);
        do_commit(0, 0);
        do_fill(2, 8'h12);

        // R8: victim list overflow
        do_begin();
        do_load(8'h10); do_load(8'h11); do_load(8'h12);
        do_fill(0, 8'h30);
        do_fill(1, 8'h31);
        chk("R8 no abort below capacity", ovf_abort, 0);
        do_fill(2, 8'h32);
        chk("R8 victim overflow abort", ovf_abort, 1);
        chk("R8 txn ended", in_txn, 0);
        for (int w = 0; w < 3; w++) do_fill(w, 8'(8'h10 + w));

        // R8: store buffer overflow
        do_begin();
        for (int i = 0; i < SD; i++) do_store(8'(8'h60 + i), 8'(i));
        chk("R8 full buffer no abort yet", ovf_abort, 0);
        do_store(8'h6f, 8'hff);
        chk("R8 store overflow abort", ovf_abort, 1);
        chk("R8 txn ended after store abort", in_txn, 0);

        // R9: snoop during burst ignored
        do_begin();
        do_load(8'h10);
        do_store(8'h70, 8'h01);
        do_store(8'h71, 8'h02);
        tx_end = 1; step(); tx_end = 0;
        bc_gnt = 1; step();
        chk("R9 burst started", bc_valid, 1);
        do_snoop(8'h10);
        chk("R9 no rollback in burst", rollback, 0);
        chk("R9 second beat addr", bc_addr, 8'h71);
        step();
        chk("R9 burst completed", commit_done, 1);
        chk("R9 still no rollback", rollback, 0);
        bc_gnt = 0;

        // R10: conflict and tx_end together
        do_begin();
        do_load(8'h10);
        do_store(8'h72, 8'h03);
        tx_end = 1; snp_valid = 1; snp_addr = 8'h10; step();
        tx_end = 0; snp_valid = 0;
        chk("R10 rollback wins", rollback, 1);
        chk("R10 no commit", commit_done, 0);
        chk("R10 no request", bc_req, 0);

        // R7: state cleared between transactions
        do_begin();
        do_load(8'h13);
        do_store(8'h99, 8'h5a);
        do_snoop(8'h13);
        chk("R7 first txn rolled back", rollback, 1);
        do_begin();
        do_snoop(8'h13);
        chk("R7 old mark cleared", rollback, 0);
        ea[0] = 8'ha1; ed[0] = 8'h3c;
        do_store(ea[0], ed[0]);
        do_commit(1, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule